// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Mask Bank

This block gathers the interrupt sources of a serial flash controller into one status word. Two sources are error events, receive overflow and transmit underflow, which are latched until software clears them. Four are level conditions taken from the FIFOs, and these follow the FIFO fill levels every cycle. The status word is gated by an enable mask, and the result drives a single registered, level-sensitive interrupt line.

Software uses a 32-bit register port. Writes take effect at the clock edge, and reads return data combinationally from the read address. The mask has no register that can be written directly. One address sets mask bits and a second address clears them, and a third, read-only address returns the current mask. Two threshold registers control when the transmit not-full flag and the receive not-empty flag are asserted.

The address decoder uses an enumerated register select with these values: `SEL_NONE`, `SEL_STATUS`, `SEL_MASK_SET`, `SEL_MASK_CLR`, `SEL_MASK_VIEW`, `SEL_TX_THR` and `SEL_RX_THR`. The write side and the read side each have their own decoder, so a write and a read can target different registers in the same cycle. The only sequential elements are the two sticky bits, the mask, the two thresholds and the interrupt flop. No multi-state sequencer is needed.

Top module: `spi_irq_bank`

## Requirements
- R1: The status register is at address 0x04, and its bit positions are fixed. Bit 0 is receive overflow, bit 2 is transmit not-full, bit 3 is transmit full, bit 4 is receive not-empty, bit 5 is receive full and bit 6 is transmit underflow. All other bits read as zero.
- R2: A one-cycle event pulse on `rx_ovf_evt` sets status bit 0, and one on `tx_udf_evt` sets status bit 6. Each bit stays set until a write to 0x04 with a one in that bit position.
- R3: If an event pulse and a write-one-to-clear reach the same sticky bit in the same cycle, the bit is set after that clock edge.
- R4: Status bits 2, 3, 4 and 5 follow the FIFO level inputs in the same cycle. A write to 0x04 does not change them.
- R5: Transmit not-full is 1 when `tx_level` is less than the transmit threshold. Receive not-empty is 1 when `rx_level` is at least the receive threshold. The thresholds are read/write registers at 0x28 (transmit) and 0x2C (receive), each with a reset value of 1.
- R6: Transmit full is 1 exactly when `tx_level` equals DEPTH (63 by default). Receive full is 1 exactly when `rx_level` equals DEPTH.
- R7: A write to 0x08 sets every mask bit whose data bit is one. A write to 0x0C clears every mask bit whose data bit is one. Bits written as zero keep their value. The mask reads at 0x10, and only bits 0 and 2 to 6 can be set. Addresses 0x08 and 0x0C read as zero.
- R8: After reset the mask is zero, both sticky bits are zero, and `irq` is low.
- R9: `irq` equals the OR over all bits of (status AND mask) from the previous cycle.
- R10: A write of 0xFFFFFFFF to 0x04 followed by a write of 0xFFFFFFFF to 0x0C leaves no sticky bit pending and no mask bit set, so `irq` is low from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| tx_level | input | 6 | Transmit FIFO fill level |
| rx_level | input | 6 | Receive FIFO fill level |
| rx_ovf_evt | input | 1 | Receive overflow event pulse |
| tx_udf_evt | input | 1 | Transmit underflow event pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench aims at the following corner cases:

- **Set and clear in the same cycle.** The bench fires an event and its clear in the same cycle. A design that gives the clear priority would lose the event, and status bit 0 or bit 6 would read as zero.
- **Writing ones over level bits.** The bench writes all ones to the status address while the level flags are active. A design that treats every status bit as sticky would latch or drop these flags, so the status readback would stop tracking the level inputs.
- **Threshold boundaries.** The bench moves the levels across the threshold value in both directions, including a threshold of 1. An off-by-one comparison would change the readback exactly at the boundary.
- **Mask set and clear.** The bench uses partial masks on the set and clear addresses. A design that stored the written word instead of setting or clearing bits would alter unrelated mask bits, and `irq` would then rise or fall in the wrong cycle.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int NUM_SRC = 7;

    localparam int BIT_RX_OVF  = 0;
    localparam int BIT_TX_NF   = 2;
    localparam int BIT_TX_FULL = 3;
    localparam int BIT_RX_NE   = 4;
    localparam int BIT_RX_FULL = 5;
    localparam int BIT_TX_UDF  = 6;

    localparam logic [NUM_SRC-1:0] SRC_VALID = 7'b111_1101;

    localparam logic [7:0] ADR_STATUS    = 8'h04;
    localparam logic [7:0] ADR_MASK_SET  = 8'h08;
    localparam logic [7:0] ADR_MASK_CLR  = 8'h0C;
    localparam logic [7:0] ADR_MASK_VIEW = 8'h10;
    localparam logic [7:0] ADR_TX_THR    = 8'h28;
    localparam logic [7:0] ADR_RX_THR    = 8'h2C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK_SET,
        SEL_MASK_CLR,
        SEL_MASK_VIEW,
        SEL_TX_THR,
        SEL_RX_THR
    } reg_sel_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        unique case (addr)
            ADR_STATUS:    sel = SEL_STATUS;
            ADR_MASK_SET:  sel = SEL_MASK_SET;
            ADR_MASK_CLR:  sel = SEL_MASK_CLR;
            ADR_MASK_VIEW: sel = SEL_MASK_VIEW;
            ADR_TX_THR:    sel = SEL_TX_THR;
            ADR_RX_THR:    sel = SEL_RX_THR;
            default:       sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

    // R3: an event wins over a clear in the same cycle
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    // R2: without a clear, a latched event is kept
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o);

    // R2: a clear with no event empties the bit
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/irq_level_flags.sv
module irq_level_flags #(
    parameter int DEPTH = 63,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_thr,
    output logic             tx_not_full,
    output logic             tx_full,
    output logic             rx_not_empty,
    output logic             rx_full
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    always_comb begin
        tx_not_full  = tx_level < tx_thr;
        rx_not_empty = rx_level >= rx_thr;
        tx_full      = tx_level == FULL_LVL;
        rx_full      = rx_level == FULL_LVL;
    end

endmodule

// File: rtl/spi_irq_bank.sv
module spi_irq_bank
    import spi_irq_pkg::*;
#(
    parameter int DEPTH  = 63,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_ovf_evt,
    input  logic              tx_udf_evt,
    output logic              irq
);

    localparam int N_STICKY = 2;
    localparam int STICKY_POS [N_STICKY] = '{BIT_RX_OVF, BIT_TX_UDF};

    reg_sel_e wsel, rsel;
    logic [NUM_SRC-1:0] status, mask_q, pend;
    logic [LVL_W-1:0]   tx_thr_q, rx_thr_q;
    logic [N_STICKY-1:0] sticky_q, sticky_set;
    logic tx_nf, tx_fl, rx_ne, rx_fl;
    logic stat_wr;
    logic [NUM_SRC-1:0] wbits;

    assign wbits   = wr_data[NUM_SRC-1:0] & SRC_VALID;
    assign stat_wr = wr_en && (wsel == SEL_STATUS);
    assign sticky_set = {tx_udf_evt, rx_ovf_evt};

    irq_reg_decode #(.ADDR_W(ADDR_W)) u_wdec (.addr(wr_addr), .sel(wsel));
    irq_reg_decode #(.ADDR_W(ADDR_W)) u_rdec (.addr(rd_addr), .sel(rsel));

    irq_level_flags #(.DEPTH(DEPTH)) u_lvl (
        .tx_level    (tx_level),
        .rx_level    (rx_level),
        .tx_thr      (tx_thr_q),
        .rx_thr      (rx_thr_q),
        .tx_not_full (tx_nf),
        .tx_full     (tx_fl),
        .rx_not_empty(rx_ne),
        .rx_full     (rx_fl)
    );

    for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
        irq_sticky_bit u_bit (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(sticky_set[g]),
            .clr_i(stat_wr && wr_data[STICKY_POS[g]]),
            .q_o  (sticky_q[g])
        );
    end

    always_comb begin
        status = '0;
        status[BIT_RX_OVF]  = sticky_q[0];
        status[BIT_TX_UDF]  = sticky_q[1];
        status[BIT_TX_NF]   = tx_nf;
        status[BIT_TX_FULL] = tx_fl;
        status[BIT_RX_NE]   = rx_ne;
        status[BIT_RX_FULL] = rx_fl;
        pend = status & mask_q;
    end

    // Mask and threshold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            tx_thr_q <= LVL_W'(1);
            rx_thr_q <= LVL_W'(1);
        end else if (wr_en) begin
            unique case (wsel)
                SEL_MASK_SET: mask_q   <= mask_q | wbits;
                SEL_MASK_CLR: mask_q   <= mask_q & ~wbits;
                SEL_TX_THR:   tx_thr_q <= wr_data[LVL_W-1:0];
                SEL_RX_THR:   rx_thr_q <= wr_data[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    // Interrupt output register
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |pend;
    end

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        unique case (rsel)
            SEL_STATUS:    rd_data[NUM_SRC-1:0] = status;
            SEL_MASK_VIEW: rd_data[NUM_SRC-1:0] = mask_q;
            SEL_TX_THR:    rd_data[LVL_W-1:0]   = tx_thr_q;
            SEL_RX_THR:    rd_data[LVL_W-1:0]   = rx_thr_q;
            default: ;
        endcase
    end

    // R7: a set write turns on every written valid bit
    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == SEL_MASK_SET) |=>
            ((mask_q & $past(wbits)) == $past(wbits)));

    // R7: a clear write turns off every written bit
    a_r7_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == SEL_MASK_CLR) |=> ((mask_q & $past(wbits)) == '0));

    // R7: the mask moves only on set or clear writes
    a_r7_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wsel == SEL_MASK_SET || wsel == SEL_MASK_CLR)) |=> $stable(mask_q));

    // R9: nothing pending means the line is low next cycle
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> !irq);

endmodule

// File: tb/sim_spi_irq_bank.sv
module sim_spi_irq_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h04;
    logic [31:0] rd_data;
    logic [5:0]  tx_level = '0;
    logic [5:0]  rx_level = '0;
    logic        rx_ovf_evt = 1'b0;
    logic        tx_udf_evt = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    int m_ovf = 0, m_udf = 0, m_mask = 0, m_txt = 1, m_rxt = 1, m_irq = 0;

    always #5 clk = ~clk;

    spi_irq_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_level(tx_level), .rx_level(rx_level),
        .rx_ovf_evt(rx_ovf_evt), .tx_udf_evt(tx_udf_evt), .irq(irq)
    );

    function automatic int model_status();
        int s = 0;
        if (m_ovf != 0) s |= 1;
        if (m_udf != 0) s |= 64;
        if (int'(tx_level) < m_txt) s |= 4;
        if (tx_level == 6'd63) s |= 8;
        if (int'(rx_level) >= m_rxt) s |= 16;
        if (rx_level == 6'd63) s |= 32;
        return s;
    endfunction

    function automatic int model_read(input int a);
        case (a)
            4:  return model_status();
            16: return m_mask;
            40: return m_txt;
            44: return m_rxt;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One clock: apply inputs, check readback, clock, update model, check irq
    task automatic cyc(input bit we, input int wa, input int wd,
                       input int txl, input int rxl, input bit ov, input bit ud,
                       input int ra, input string tag);
        int wbits;
        wr_en = we; wr_addr = 8'(wa); wr_data = wd;
        tx_level = 6'(txl); rx_level = 6'(rxl);
        rx_ovf_evt = ov; tx_udf_evt = ud; rd_addr = 8'(ra);
        #2;
        check({tag, " read"}, int'(rd_data), model_read(ra));
        @(posedge clk);
        m_irq = ((model_status() & m_mask) != 0) ? 1 : 0;
        wbits = wd & 'h7D;
        if (ov) m_ovf = 1; else if (we && wa == 4 && (wd & 1) != 0) m_ovf = 0;
        if (ud) m_udf = 1; else if (we && wa == 4 && (wd & 64) != 0) m_udf = 0;
        if (we && wa == 8)  m_mask |= wbits;
        if (we && wa == 12) m_mask &= ~wbits;
        if (we && wa == 40) m_txt = wd & 63;
        if (we && wa == 44) m_rxt = wd & 63;
        #1;
        check({tag, " irq"}, int'(irq), m_irq);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
            begin
                repeat (3) @(posedge clk);
                #1 rst_n = 1'b1;
                // R8 reset state
                check("R8 irq", int'(irq), 0);
                cyc(0, 0, 0, 5, 0, 0, 0, 16, "R8 mask");
                cyc(0, 0, 0, 5, 0, 0, 0, 4, "R8 status");
                cyc(0, 0, 0, 5, 0, 0, 0, 40, "R5 txthr reset");
                cyc(0, 0, 0, 5, 0, 0, 0, 44, "R5 rxthr reset");
                // R1 / R4 / R5 / R6 level flags
                cyc(0, 0, 0, 0, 1, 0, 0, 4, "R1 R5 empty tx, one rx");
                cyc(0, 0, 0, 63, 63, 0, 0, 4, "R6 both full");
                cyc(0, 0, 0, 62, 62, 0, 0, 4, "R6 one short of full");
                cyc(1, 4, -1, 0, 5, 0, 0, 4, "R4 w1 on level bits");
                cyc(0, 0, 0, 0, 5, 0, 0, 4, "R4 level after write");
                cyc(1, 40, 10, 9, 3, 0, 0, 40, "R5 set tx thr");
                cyc(1, 44, 4, 9, 3, 0, 0, 4, "R5 set rx thr");
                cyc(0, 0, 0, 9, 3, 0, 0, 4, "R5 below thr");
                cyc(0, 0, 0, 10, 4, 0, 0, 4, "R5 at thr");
                cyc(0, 0, 0, 11, 5, 0, 0, 4, "R5 above thr");
                cyc(1, 40, 1, 0, 0, 0, 0, 4, "R5 back to 1");
                cyc(1, 44, 1, 1, 0, 0, 0, 4, "R5 rx back to 1");
                cyc(0, 0, 0, 1, 0, 0, 0, 4, "R5 thr 1 nonempty tx");
                // R2 / R3 sticky
                cyc(0, 0, 0, 5, 0, 1, 0, 4, "R2 ovf pulse");
                cyc(0, 0, 0, 5, 0, 0, 0, 4, "R2 ovf held");
                cyc(0, 0, 0, 5, 0, 0, 1, 4, "R2 udf pulse");
                cyc(1, 4, 1, 5, 0, 0, 0, 4, "R2 clear ovf only");
                cyc(0, 0, 0, 5, 0, 0, 0, 4, "R2 udf remains");
                cyc(1, 4, 64, 5, 0, 0, 1, 4, "R3 udf set and clear");
                cyc(0, 0, 0, 5, 0, 0, 0, 4, "R3 udf still set");
                cyc(1, 4, 1, 5, 0, 1, 0, 4, "R3 ovf set and clear");
                cyc(0, 0, 0, 5, 0, 0, 0, 4, "R3 ovf still set");
                // R7 / R9 mask and irq
                cyc(1, 8, 'h02, 5, 0, 0, 0, 16, "R7 reserved bit");
                cyc(0, 0, 0, 5, 0, 0, 0, 16, "R7 reserved stays 0");
                cyc(1, 8, 'h10, 5, 0, 0, 0, 8, "R7 set rx ne, 0x08 reads 0");
                cyc(0, 0, 0, 5, 0, 0, 0, 16, "R9 masked source idle");
                cyc(0, 0, 0, 5, 3, 0, 0, 16, "R9 rx ne raises irq");
                cyc(0, 0, 0, 5, 0, 0, 0, 12, "R9 irq drops, 0x0C reads 0");
                cyc(1, 8, 'h41, 5, 0, 0, 0, 16, "R7 set sticky bits");
                cyc(0, 0, 0, 5, 0, 0, 0, 16, "R9 sticky pending");
                cyc(1, 12, 'h01, 5, 0, 0, 0, 16, "R7 clear bit 0 only");
                cyc(0, 0, 0, 5, 0, 0, 0, 16, "R7 others kept");
                cyc(1, 8, 'h0C, 63, 0, 0, 0, 16, "R7 set tx bits");
                cyc(0, 0, 0, 63, 0, 0, 0, 16, "R9 tx full");
                // R10 clear-all sequence
                cyc(1, 4, -1, 5, 0, 0, 0, 4, "R10 clear status");
                cyc(1, 12, -1, 5, 0, 0, 0, 4, "R10 disable all");
                cyc(0, 0, 0, 0, 9, 0, 0, 16, "R10 mask empty");
                cyc(0, 0, 0, 63, 63, 0, 0, 4, "R10 no irq with levels");
                cyc(0, 0, 0, 5, 0, 0, 0, 4, "R10 settle");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule